// File: doc/BRIEF.md
# Batched Memory Port Traffic Sequencer

This block drives one bidirectional user port of a DRAM controller. It runs a batch of fixed-size burst reads, then the same number of burst writes, and aims for the highest throughput the port allows. The controller and its memory are outside the block. Toward the controller, the block sees three things: a command queue, a read-data FIFO with first-word-fall-through output, and a write-data FIFO. Toward the fabric, it presents a downstream stream that carries read data and an upstream stream that supplies write data.

Three activities run at the same time: issuing commands, draining read data and filling write data. Read commands go out back to back, with no wait for earlier reads to complete. Space for each burst is first reserved in the read-data FIFO, so that FIFO can never overrun. All read commands are queued before the first write command, which limits the memory bus to a single change of direction per batch. A write command goes out only once its whole burst sits in the write-data FIFO.

Every flow-control decision uses only the empty and full flags. The occupancy counts of the controller's FIFOs are never used.

Top module: `mem_batch_seq`

## Requirements
- R1: Before a start, and after reset, `busy`, `done`, `cmd_en`, `rdf_pop` and `ws_ready` are all low.
- R2: Every command carries a burst-length code of 63 (word count minus one) for a 64-word burst of 128-bit words.
- R3: `cmd_en` is never asserted while `cmd_full` is high.
- R4: A batch of N (`batch_len`) issues exactly N read commands (`cmd_is_wr`=0) and N write commands (`cmd_is_wr`=1), and no read command follows a write command within the batch.
- R5: A read command is issued only when 64 words of unreserved read-FIFO space exist. The total space is `RDF_WORDS` (default 128). Each read command reserves 64 words, and each pop returns one word. The words requested but not yet popped never exceed `RDF_WORDS`.
- R6: While busy, `rs_valid` is high exactly when `rdf_empty` is low. `rdf_pop` fires on `rs_valid && rs_ready`. The data passes through unchanged and in order, N*64 words in total.
- R7: `wdf_push` fires on `ws_valid && ws_ready`. `ws_ready` is low while `wdf_full` is high and once N*64 words have been accepted. Exactly N*64 words are pushed, in order.
- R8: Write command k (counted from 0) is issued only after (k+1)*64 words have been pushed.
- R9: Read command k has address `rd_base` + k*1024, and write command k has address `wr_base` + k*1024, which is one burst of 16-byte words.
- R10: `done` is high for exactly one cycle, once the last write command is accepted and all N*64 read words have been drained. `busy` is low in that same cycle.
- R11: A `start` that arrives while `busy` is high is ignored. The running batch keeps its counts and addresses.
- R12: A batch with N=0 issues no commands and raises `done` within three cycles of the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a batch (taken when idle) |
| rd_base | input | 32 | First read address |
| wr_base | input | 32 | First write address |
| batch_len | input | 8 | Bursts per direction (N) |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_en | output | 1 | Command push into controller queue |
| cmd_is_wr | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | 32 | Command address |
| cmd_bl | output | 6 | Burst-length code |
| cmd_full | input | 1 | Command queue full |
| rdf_empty | input | 1 | Read-data FIFO empty |
| rdf_data | input | 128 | Read-data FIFO head word |
| rdf_pop | output | 1 | Read-data FIFO pop |
| rs_valid | output | 1 | Downstream read stream valid |
| rs_data | output | 128 | Downstream read stream data |
| rs_ready | input | 1 | Downstream read stream ready |
| ws_valid | input | 1 | Upstream write stream valid |
| ws_data | input | 128 | Upstream write stream data |
| ws_ready | output | 1 | Upstream write stream ready |
| wdf_full | input | 1 | Write-data FIFO full |
| wdf_push | output | 1 | Write-data FIFO push |
| wdf_data | output | 128 | Write-data FIFO word |

## Verification
A corrupted reservation count shows up within one burst. The controller model then sees its read FIFO overflow, or reads stall while space is plainly free. A wrong write-credit count makes the model's write engine find an empty FIFO in the first cycle it services the early write command. A bad command or address counter appears at once on `cmd_addr` or in the read/write ordering, and it corrupts the returned read data within the same burst. A faulty completion term either never raises `done`, which the run limit catches, or raises it before the command and word totals are reached.

// File: rtl/mbs_pkg.sv
// Shared types for the batched memory port sequencer.
package mbs_pkg;
    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } cmd_dir_e;
endpackage

// File: rtl/mbs_cmd_issuer.sv
// Command issuer: picks the next read or write command for the controller queue.
// All reads of the batch go first, then all writes. A read needs reserved
// read-FIFO space; a write needs one complete burst already in the write FIFO.
// Assumes the queue accepts a push in any cycle where cmd_full is low.
module mbs_cmd_issuer
    import mbs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 8,
    parameter int BL_W        = 6,
    parameter int BURST_WORDS = 64,
    parameter int ADDR_STEP   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic [CNT_W-1:0]  n_bursts,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic              rd_space_ok,
    input  logic              wr_data_ok,
    input  logic              cmd_full,
    output logic              cmd_en,
    output cmd_dir_e          cmd_dir,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BL_W-1:0]   cmd_bl,
    output logic              rd_issue,
    output logic              wr_issue,
    output logic              all_issued
);
    localparam logic [BL_W-1:0]   BL_CODE = BL_W'(BURST_WORDS - 1);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(ADDR_STEP);

    logic [CNT_W-1:0]  rd_cnt, wr_cnt;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              rd_left, wr_left, want_rd, want_wr;

    // Select the eligible command; reads have priority until all are issued.
    always_comb begin
        rd_left    = (rd_cnt != n_bursts);
        wr_left    = (wr_cnt != n_bursts);
        want_rd    = active && rd_left && rd_space_ok;
        want_wr    = active && !rd_left && wr_left && wr_data_ok;
        cmd_en     = (want_rd || want_wr) && !cmd_full;
        cmd_dir    = want_rd ? CMD_READ : CMD_WRITE;
        cmd_addr   = want_rd ? rd_addr : wr_addr;
        cmd_bl     = BL_CODE;
        rd_issue   = cmd_en && want_rd;
        wr_issue   = cmd_en && !want_rd;
        all_issued = !rd_left && !wr_left;
    end

    // Advance command counters and addresses on each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            rd_addr <= '0;
            wr_addr <= '0;
        end else if (clr) begin
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            rd_addr <= rd_base;
            wr_addr <= wr_base;
        end else begin
            if (rd_issue) begin
                rd_cnt  <= rd_cnt + 1'b1;
                rd_addr <= rd_addr + STEP;
            end
            if (wr_issue) begin
                wr_cnt  <= wr_cnt + 1'b1;
                wr_addr <= wr_addr + STEP;
            end
        end
    end
endmodule

// File: rtl/mbs_rd_drain.sv
// Read drain: forwards read-FIFO words to the downstream stream as soon as
// the FIFO is non-empty, and keeps a reservation count of unclaimed FIFO space.
// Assumes a first-word-fall-through FIFO and trusts only its empty flag.
module mbs_rd_drain #(
    parameter int DATA_W      = 128,
    parameter int RDF_WORDS   = 128,
    parameter int BURST_WORDS = 64,
    parameter int WCNT_W      = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic              rd_issue,
    input  logic [WCNT_W-1:0] total_words,
    input  logic              rdf_empty,
    input  logic [DATA_W-1:0] rdf_data,
    input  logic              rs_ready,
    output logic              rdf_pop,
    output logic              rs_valid,
    output logic [DATA_W-1:0] rs_data,
    output logic              space_ok,
    output logic              all_drained
);
    localparam int              SP_W     = $clog2(RDF_WORDS + 1);
    localparam logic [SP_W-1:0] SP_FULL  = SP_W'(RDF_WORDS);
    localparam logic [SP_W-1:0] SP_BURST = SP_W'(BURST_WORDS);

    logic [SP_W-1:0]   space;
    logic [WCNT_W-1:0] drained;

    // Stream handshake and space test.
    always_comb begin
        rs_valid    = active && !rdf_empty;
        rdf_pop     = rs_valid && rs_ready;
        rs_data     = rdf_data;
        space_ok    = (space >= SP_BURST);
        all_drained = (drained == total_words);
    end

    // Reserve a burst per read command, release a word per pop; count drained words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space   <= SP_FULL;
            drained <= '0;
        end else if (clr) begin
            space   <= SP_FULL;
            drained <= '0;
        end else begin
            space <= space - (rd_issue ? SP_BURST : '0) + (rdf_pop ? SP_W'(1) : '0);
            if (rdf_pop) drained <= drained + 1'b1;
        end
    end
endmodule

// File: rtl/mbs_wr_fill.sv
// Write fill: moves upstream words into the write FIFO without overflow and
// counts whole bursts staged there as write credits for the command issuer.
// Assumes the FIFO full flag is valid in the cycle it is sampled.
module mbs_wr_fill #(
    parameter int DATA_W      = 128,
    parameter int BURST_WORDS = 64,
    parameter int WCNT_W      = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic [WCNT_W-1:0] total_words,
    input  logic              ws_valid,
    input  logic [DATA_W-1:0] ws_data,
    input  logic              wdf_full,
    input  logic              wr_issue,
    output logic              ws_ready,
    output logic              wdf_push,
    output logic [DATA_W-1:0] wdf_data,
    output logic              credit_ok
);
    localparam int               BEAT_W    = $clog2(BURST_WORDS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_WORDS - 1);

    logic [WCNT_W-1:0] pushed;
    logic [BEAT_W-1:0] beat;
    logic [WCNT_W-1:0] credits;
    logic              burst_done;

    // Accept upstream data while room remains and the batch still needs words.
    always_comb begin
        ws_ready   = active && !wdf_full && (pushed != total_words);
        wdf_push   = ws_valid && ws_ready;
        wdf_data   = ws_data;
        burst_done = wdf_push && (beat == LAST_BEAT);
        credit_ok  = (credits != '0);
    end

    // Track pushed words, beat position and staged bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pushed  <= '0;
            beat    <= '0;
            credits <= '0;
        end else if (clr) begin
            pushed  <= '0;
            beat    <= '0;
            credits <= '0;
        end else begin
            if (wdf_push) begin
                pushed <= pushed + 1'b1;
                beat   <= burst_done ? '0 : beat + 1'b1;
            end
            credits <= credits + (burst_done ? WCNT_W'(1) : '0) - (wr_issue ? WCNT_W'(1) : '0);
        end
    end
endmodule

// File: rtl/mem_batch_seq.sv
// Batched memory port sequencer top: latches a batch on start, runs command
// issue, read drain and write fill concurrently, and pulses done at the end.
// Assumes batch parameters are stable only in the start cycle.
module mem_batch_seq
    import mbs_pkg::*;
#(
    parameter int DATA_W      = 128,
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 8,
    parameter int BL_W        = 6,
    parameter int BURST_WORDS = 64,
    parameter int RDF_WORDS   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [CNT_W-1:0]  batch_len,
    output logic              busy,
    output logic              done,
    output logic              cmd_en,
    output logic              cmd_is_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BL_W-1:0]   cmd_bl,
    input  logic              cmd_full,
    input  logic              rdf_empty,
    input  logic [DATA_W-1:0] rdf_data,
    output logic              rdf_pop,
    output logic              rs_valid,
    output logic [DATA_W-1:0] rs_data,
    input  logic              rs_ready,
    input  logic              ws_valid,
    input  logic [DATA_W-1:0] ws_data,
    output logic              ws_ready,
    input  logic              wdf_full,
    output logic              wdf_push,
    output logic [DATA_W-1:0] wdf_data
);
    localparam int BEAT_W    = $clog2(BURST_WORDS);
    localparam int WCNT_W    = CNT_W + BEAT_W;
    localparam int ADDR_STEP = BURST_WORDS * (DATA_W / 8);

    logic              busy_r, done_r, accept, complete;
    logic [CNT_W-1:0]  n_r;
    logic [WCNT_W-1:0] total_words;
    logic              space_ok, credit_ok, rd_issue, wr_issue, all_issued, all_drained;
    cmd_dir_e          dir;

    // Batch control terms.
    always_comb begin
        accept      = start && !busy_r;
        complete    = busy_r && all_issued && all_drained;
        total_words = WCNT_W'(n_r) * WCNT_W'(BURST_WORDS);
        busy        = busy_r;
        done        = done_r;
        cmd_is_wr   = (dir == CMD_WRITE);
    end

    // Batch state: latch length on start, drop busy and pulse done at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_r <= 1'b0;
            done_r <= 1'b0;
            n_r    <= '0;
        end else begin
            done_r <= complete;
            if (accept) begin
                busy_r <= 1'b1;
                n_r    <= batch_len;
            end else if (complete) begin
                busy_r <= 1'b0;
            end
        end
    end

    mbs_cmd_issuer #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BL_W(BL_W),
        .BURST_WORDS(BURST_WORDS), .ADDR_STEP(ADDR_STEP)
    ) i_issuer (
        .clk(clk), .rst_n(rst_n), .clr(accept), .active(busy_r),
        .n_bursts(n_r), .rd_base(rd_base), .wr_base(wr_base),
        .rd_space_ok(space_ok), .wr_data_ok(credit_ok), .cmd_full(cmd_full),
        .cmd_en(cmd_en), .cmd_dir(dir), .cmd_addr(cmd_addr), .cmd_bl(cmd_bl),
        .rd_issue(rd_issue), .wr_issue(wr_issue), .all_issued(all_issued)
    );

    mbs_rd_drain #(
        .DATA_W(DATA_W), .RDF_WORDS(RDF_WORDS),
        .BURST_WORDS(BURST_WORDS), .WCNT_W(WCNT_W)
    ) i_drain (
        .clk(clk), .rst_n(rst_n), .clr(accept), .active(busy_r),
        .rd_issue(rd_issue), .total_words(total_words),
        .rdf_empty(rdf_empty), .rdf_data(rdf_data), .rs_ready(rs_ready),
        .rdf_pop(rdf_pop), .rs_valid(rs_valid), .rs_data(rs_data),
        .space_ok(space_ok), .all_drained(all_drained)
    );

    mbs_wr_fill #(
        .DATA_W(DATA_W), .BURST_WORDS(BURST_WORDS), .WCNT_W(WCNT_W)
    ) i_fill (
        .clk(clk), .rst_n(rst_n), .clr(accept), .active(busy_r),
        .total_words(total_words), .ws_valid(ws_valid), .ws_data(ws_data),
        .wdf_full(wdf_full), .wr_issue(wr_issue),
        .ws_ready(ws_ready), .wdf_push(wdf_push), .wdf_data(wdf_data),
        .credit_ok(credit_ok)
    );
endmodule

// File: rtl/mem_batch_seq_chk.sv
// Protocol checker for mem_batch_seq, attached by bind. Observes ports only.
module mem_batch_seq_chk #(
    parameter int BL_W        = 6,
    parameter int BURST_WORDS = 64,
    parameter int RDF_WORDS   = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            cmd_en,
    input logic            cmd_is_wr,
    input logic [BL_W-1:0] cmd_bl,
    input logic            cmd_full,
    input logic            rdf_empty,
    input logic            rdf_pop,
    input logic            ws_ready,
    input logic            wdf_full,
    input logic            wdf_push
);
    logic [31:0] outstanding;
    logic        wr_seen;

    // Track read words requested but not yet popped, and whether a write has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            wr_seen     <= 1'b0;
        end else begin
            outstanding <= outstanding + ((cmd_en && !cmd_is_wr) ? 32'(BURST_WORDS) : 32'd0)
                                       - (rdf_pop ? 32'd1 : 32'd0);
            if (start && !busy)          wr_seen <= 1'b0;
            else if (cmd_en && cmd_is_wr) wr_seen <= 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_en && !rdf_pop && !ws_ready));
    p_bl_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> (cmd_bl == BL_W'(BURST_WORDS - 1)));
    p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |-> !cmd_full);
    p_rd_before_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && !cmd_is_wr) |-> !wr_seen);
    p_resv_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= 32'(RDF_WORDS));
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdf_pop |-> !rdf_empty);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdf_push |-> !wdf_full);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind mem_batch_seq mem_batch_seq_chk #(
    .BL_W(BL_W), .BURST_WORDS(BURST_WORDS), .RDF_WORDS(RDF_WORDS)
) i_chk (.*);

// File: tb/test_mem_batch_seq.sv
module test_mem_batch_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  rd_base = '0, wr_base = '0;
    logic [7:0]   batch_len = '0;
    logic         busy, done, cmd_en, cmd_is_wr, rdf_pop, rs_valid, ws_ready, wdf_push;
    logic [31:0]  cmd_addr;
    logic [5:0]   cmd_bl;
    logic         cmd_full, rdf_empty, wdf_full;
    logic [127:0] rdf_data, rs_data, ws_data, wdf_data;
    logic         rs_ready = 1'b0, ws_valid = 1'b0;

    int n_checks = 0, n_fail = 0;
    int rdy_pct = 100, vld_pct = 100;

    always #4 clk = ~clk;

    mem_batch_seq i_mem_batch_seq (.*);

    function automatic logic [127:0] rd_word(input logic [31:0] a, input int b);
        return {a, 32'(b), a ^ 32'hC3C3_5A5A, a + 32'(b) * 32'd17};
    endfunction
    function automatic logic [127:0] wr_word(input int i);
        return {32'(i), ~32'(i), 32'(i) * 32'd13, 32'h0BAD_F00D};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- controller model: command queue, read FIFO, write FIFO
    logic         cq_wr[4];
    logic [31:0]  cq_addr[4];
    int           cq_wp, cq_rp, cq_cnt;
    logic [127:0] rmem[128];
    int           rwp, rrp, rcnt;
    logic [127:0] wmem[128];
    int           wwp, wrp, wcnt;
    logic         eng_busy, eng_wr;
    logic [31:0]  eng_addr;
    int           eng_beat, eng_wait;
    int           m_overrun = 0, m_starve = 0, m_wdata = 0, m_wover = 0, m_under = 0, m_widx = 0;
    int           ws_idx;

    assign cmd_full  = (cq_cnt == 4);
    assign rdf_empty = (rcnt == 0);
    assign rdf_data  = rmem[rrp];
    assign wdf_full  = (wcnt == 128);
    assign ws_data   = wr_word(ws_idx);

    always @(posedge clk) begin : model
        int cpush, ctake, rpush, wpop;
        cpush = 0; ctake = 0; rpush = 0; wpop = 0;
        if (!rst_n) begin
            cq_wp <= 0; cq_rp <= 0; cq_cnt <= 0;
            rwp <= 0; rrp <= 0; rcnt <= 0;
            wwp <= 0; wrp <= 0; wcnt <= 0;
            eng_busy <= 1'b0; eng_wr <= 1'b0; eng_addr <= '0; eng_beat <= 0; eng_wait <= 0;
        end else begin
            if (cmd_en && cq_cnt < 4) begin
                cq_wr[cq_wp] <= cmd_is_wr; cq_addr[cq_wp] <= cmd_addr;
                cq_wp <= (cq_wp + 1) % 4; cpush = 1;
            end
            if (!eng_busy && cq_cnt != 0) begin
                eng_busy <= 1'b1; eng_wr <= cq_wr[cq_rp]; eng_addr <= cq_addr[cq_rp];
                eng_beat <= 0; eng_wait <= int'($urandom % 8);
                cq_rp <= (cq_rp + 1) % 4; ctake = 1;
            end else if (eng_busy) begin
                if (eng_wait != 0) eng_wait <= eng_wait - 1;
                else if ($urandom % 4 != 0) begin
                    if (!eng_wr) begin
                        if (rcnt == 128) m_overrun++;
                        else begin
                            rmem[rwp] <= rd_word(eng_addr, eng_beat);
                            rwp <= (rwp + 1) % 128; rpush = 1;
                            eng_beat <= eng_beat + 1;
                            if (eng_beat == 63) eng_busy <= 1'b0;
                        end
                    end else begin
                        if (wcnt == 0) m_starve++;
                        else begin
                            if (wmem[wrp] != wr_word(m_widx)) m_wdata++;
                            m_widx++;
                            wrp <= (wrp + 1) % 128; wpop = 1;
                            eng_beat <= eng_beat + 1;
                            if (eng_beat == 63) eng_busy <= 1'b0;
                        end
                    end
                end
            end
            if (rdf_pop) begin
                if (rcnt == 0) m_under++;
                rrp <= (rrp + 1) % 128;
            end
            if (wdf_push) begin
                if (wcnt == 128) m_wover++;
                wmem[wwp] <= wdf_data; wwp <= (wwp + 1) % 128;
            end
            cq_cnt <= cq_cnt + cpush - ctake;
            rcnt   <= rcnt + rpush - (rdf_pop ? 1 : 0);
            wcnt   <= wcnt + (wdf_push ? 1 : 0) - wpop;
        end
    end

    // ---------------- port monitor
    int          mon_rd, mon_wr, e_bl, e_full, e_order, e_addr, e_early, e_resv, e_data, e_done;
    int          rs_cnt, ws_cnt, outst, mon_done;
    logic [31:0] exp_rb, exp_wb;
    logic        prev_done = 1'b0;

    always @(posedge clk) begin : monitor
        if (!rst_n) ws_idx <= 0;
        else begin
            if (start && !busy) begin
                mon_rd = 0; mon_wr = 0; e_bl = 0; e_full = 0; e_order = 0; e_addr = 0;
                e_early = 0; e_resv = 0; e_data = 0; e_done = 0; rs_cnt = 0; ws_cnt = 0;
                outst = 0; mon_done = 0; exp_rb = rd_base; exp_wb = wr_base;
            end else begin
                if (cmd_en) begin
                    if (cmd_full) e_full++;
                    if (cmd_bl != 6'd63) e_bl++;
                    if (!cmd_is_wr) begin
                        if (mon_wr > 0) e_order++;
                        if (cmd_addr != exp_rb + 32'(mon_rd) * 32'd1024) e_addr++;
                        mon_rd++; outst += 64;
                    end else begin
                        if (cmd_addr != exp_wb + 32'(mon_wr) * 32'd1024) e_addr++;
                        if (ws_cnt < (mon_wr + 1) * 64) e_early++;
                        mon_wr++;
                    end
                end
                if (rdf_pop) begin
                    if (rs_data != rd_word(exp_rb + 32'(rs_cnt / 64) * 32'd1024, rs_cnt % 64)) e_data++;
                    if (!rs_valid) e_data++;
                    rs_cnt++; outst--;
                end
                if (outst > 128) e_resv++;
                if (ws_valid && ws_ready) begin
                    ws_cnt++; ws_idx <= ws_idx + 1;
                end
                if (done) begin
                    mon_done++;
                    if (busy || prev_done || mon_wr != int'(batch_len_r) || rs_cnt != 64 * int'(batch_len_r)) e_done++;
                end
            end
            prev_done = done;
        end
    end

    int batch_len_r;

    // Random stream pressure, changed away from the active edge.
    always @(negedge clk) begin
        rs_ready <= (($urandom % 100) < rdy_pct);
        ws_valid <= (($urandom % 100) < vld_pct);
    end

    task automatic run(input int n, input logic [31:0] rb, input logic [31:0] wb,
                       input int rp, input int vp, input bit poke, input string tag);
        int cyc;
        rdy_pct = rp; vld_pct = vp;
        batch_len_r = n;
        @(negedge clk);
        rd_base = rb; wr_base = wb; batch_len = 8'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (mon_done == 0 && cyc < 20000) begin
            if (poke && cyc == 40) begin
                start = 1'b1; rd_base = 32'hDEAD_0000; wr_base = 32'hBEEF_0000; batch_len = 8'd1;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(mon_done == 1, "R10", {tag, " done pulse count"}, mon_done, 1);
        chk(e_done == 0, "R10", {tag, " done timing/width"}, e_done, 0);
        chk(busy == 1'b0, "R10", {tag, " busy after done"}, busy, 0);
        chk(mon_rd == n && mon_wr == n && e_order == 0, "R4", {tag, " read/write counts and order"}, mon_rd * 1000 + mon_wr, n * 1001);
        chk(e_bl == 0, "R2", {tag, " burst code"}, e_bl, 0);
        chk(e_full == 0, "R3", {tag, " push while full"}, e_full, 0);
        chk(e_addr == 0, poke ? "R11" : "R9", {tag, " addresses"}, e_addr, 0);
        chk(e_early == 0 && m_starve == 0, "R8", {tag, " write before data"}, e_early + m_starve, 0);
        chk(e_resv == 0 && m_overrun == 0, "R5", {tag, " read space"}, e_resv + m_overrun, 0);
        chk(e_data == 0 && m_under == 0 && rs_cnt == n * 64, "R6", {tag, " read stream words"}, rs_cnt, n * 64);
        chk(ws_cnt == n * 64 && m_wover == 0, "R7", {tag, " write words accepted"}, ws_cnt, n * 64);
        if (n == 0) chk(cyc <= 3, "R12", {tag, " empty batch latency"}, cyc, 3);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        chk(cmd_en == 0 && rdf_pop == 0 && ws_ready == 0, "R1", "handshakes after reset",
            {cmd_en, rdf_pop, ws_ready}, 0);
        // Directed: full rate, default batch of seven
        run(7, 32'h0001_0000, 32'h0080_0000, 100, 100, 1'b0, "full-rate");
        // Slow downstream: reservation must hold reads back
        run(6, 32'h0000_4000, 32'h0010_0000, 8, 100, 1'b0, "slow-drain");
        // Slow upstream: writes wait for staged bursts
        run(5, 32'h0200_0000, 32'h0300_0000, 100, 15, 1'b0, "slow-fill");
        // Start pulsed mid-batch with other parameters: R11
        run(4, 32'h0000_8000, 32'h0004_0000, 60, 60, 1'b1, "restart-ignored");
        // Empty batch: R12
        run(0, 32'h0, 32'h0, 100, 100, 1'b0, "empty");
        // Random batches
        for (int k = 0; k < 4; k++) begin
            run(1 + int'($urandom % 9), $urandom & 32'hFFFF_FC00, $urandom & 32'hFFFF_FC00,
                10 + int'($urandom % 91), 10 + int'($urandom % 91), 1'b0, "random");
        end
        // Let the write engine finish and check every written word arrived in order: R7
        repeat (2000) @(negedge clk);
        chk(m_wdata == 0, "R7", "write data order", m_wdata, 0);
        chk(m_widx == 64 * (7 + 6 + 5 + 4) + ws_idx - 64 * (7 + 6 + 5 + 4), "R7", "write words consumed", m_widx, ws_idx);
        chk(busy == 0 && done == 0, "R1", "idle after batches", {busy, done}, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule